// File: doc/BRIEF.md
# Context Schedule Propagation Unit

This unit lets one stored instruction context apply to a run of later instructions without repeating it in each one. It holds seven independent streams. Each stream pairs a 32-bit context word with a 40-bit schedule. An insert command names a stream, stores a new context word in it, and appends a run of schedule bits after the bits that stream already holds. The schedule comes from a 21-bit immediate: its lowest set bit is a terminator, and the bits above it form the schedule. The bit just above the terminator is applied first.

Each time the surrounding pipeline issues a 32-bit instruction, it pulses `advance`. The unit looks at the head bit of every stream and ORs together the contexts of the streams whose head bit is set. All streams then drop their head bit. The bits 31:28 of a context give its kind. If the active contexts are of more than one kind, the unit reports an illegal mix and gives no merged result. An insert that would run a schedule past its 40-bit capacity raises a sticky error.

Top module: `ctxprop_unit`

## Requirements
- R1: After synchronous reset, all schedules, contexts and fill offsets are empty. `mergedValid`, `illegalMix`, `overflowErr` and `mergedCtx` are 0, and an advance before any insert yields no valid result.
- R2: An insert with `insIdx` = 0 changes no stream: no schedule, context or fill offset.
- R3: An insert appends 20 minus (trailing zeros of `insImm`) bits, namely the bits above the lowest set bit of `insImm`. The bit just above that set bit is consumed by the first advance. An immediate of 0, or one with only bit 20 set, appends nothing.
- R4: An insert places its bits starting at the stream's fill offset, directly after that stream's last pending bit. The offset then grows by the appended count.
- R5: On the clock edge where `advance` is high, the contexts of all streams whose head bit is 1 are ORed together. In the next cycle this OR appears on `mergedCtx` with `mergedValid` = 1. Every stream shifts down by one bit on that edge.
- R6: Advancing a stream with a fill offset of 0 leaves the offset at 0. A later insert therefore starts at the head position.
- R7: The context kind is bits 31:28. If the active streams in one advance hold more than one kind, the next cycle shows `illegalMix` = 1, `mergedValid` = 0 and `mergedCtx` = 0. Active streams of a single kind merge normally.
- R8: If an insert would take a fill offset above 40, `overflowErr` goes to 1 and stays at 1 until reset. Only the bits that fit are kept, and the offset saturates at 40.
- R9: When an insert and an advance arrive on the same edge, the advance takes effect first, using the old contexts. The inserted bits then go at the offset left after the shift.
- R10: In a cycle that does not follow an advance, `mergedValid` and `illegalMix` are 0. `mergedCtx` is 0 whenever `mergedValid` is 0.
- R11: An insert replaces the stream's stored context. Bits already pending in that stream then apply the new context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insValid | input | 1 | Insert command strobe |
| insIdx | input | 3 | Target stream, 1 to 7; 0 selects nothing |
| insCtx | input | 32 | Context word to store; bits 31:28 are its kind |
| insImm | input | 21 | Schedule immediate; lowest set bit terminates |
| advance | input | 1 | One 32-bit instruction issued this cycle |
| mergedCtx | output | 32 | ORed context for the last advanced instruction |
| mergedValid | output | 1 | Merged context is valid |
| illegalMix | output | 1 | Active contexts were of different kinds |
| overflowErr | output | 1 | Sticky schedule overflow error |

## Verification
The properties assume that `advance` and `insValid` are sampled as clean single-cycle strobes. They also assume that `rst` is held for at least one edge before checking starts, so every `$past` term refers to a cycle that was reset or later. The stimulus drives every input on the falling edge and holds it for exactly one rising edge. Stream indices are kept between 0 and 7, and each scenario drains the streams it fills before the next one starts. Each merge outcome can therefore be traced to the inserts of its own scenario.

// File: rtl/ctxprop_pkg.sv
package ctxprop_pkg;
  localparam int NUM_STREAMS = 7;
  localparam int IDX_W       = $clog2(NUM_STREAMS + 1);
  localparam int SCHED_W     = 40;
  localparam int IMM_W       = 21;
  localparam int PAY_W       = IMM_W - 1;
  localparam int CTX_W       = 32;
  localparam int KIND_W      = 4;
  localparam int FILL_W      = $clog2(SCHED_W + 1);
  localparam int CNT_W       = $clog2(IMM_W + 1);

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic                   adv;
    logic [NUM_STREAMS-1:0] load;
    logic [CNT_W-1:0]       count;
    logic [PAY_W-1:0]       bits;
  } strobe_t;
endpackage

// File: rtl/ctxprop_ctrl.sv
module ctxprop_ctrl
  import ctxprop_pkg::*;
(
  input  logic             insValid,
  input  logic [IDX_W-1:0] insIdx,
  input  logic [IMM_W-1:0] insImm,
  input  logic             advance,
  output strobe_t          strb
);
  logic [CNT_W-1:0] trailZeros;

  always_comb begin
    trailZeros = CNT_W'(IMM_W);
    for (int i = IMM_W - 1; i >= 0; i--) begin
      if (insImm[i]) trailZeros = CNT_W'(i);
    end
  end

  always_comb begin
    strb.adv   = advance;
    strb.count = (trailZeros >= CNT_W'(PAY_W)) ? '0 : CNT_W'(PAY_W) - trailZeros;
    strb.bits  = PAY_W'(insImm >> (trailZeros + 1'b1));
    for (int s = 0; s < NUM_STREAMS; s++) begin
      strb.load[s] = insValid && (insIdx == IDX_W'(s + 1));
    end
  end
endmodule

// File: rtl/ctxprop_datapath.sv
module ctxprop_datapath
  import ctxprop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [CTX_W-1:0] insCtx,
  output logic [CTX_W-1:0] mergedCtx,
  output logic             mergedValid,
  output logic             illegalMix,
  output logic             overflowErr
);
  logic [NUM_STREAMS-1:0] headBit;
  logic [NUM_STREAMS-1:0] ovfHit;
  logic [CTX_W-1:0]       ctxArr [NUM_STREAMS];

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    logic [SCHED_W-1:0] schedQ, schedShift, placed;
    logic [FILL_W-1:0]  fillQ, fillShift;
    logic [FILL_W:0]    fillSum;
    logic [CTX_W-1:0]   ctxQ;

    always_comb begin
      schedShift = strb.adv ? (schedQ >> 1) : schedQ;
      fillShift  = (strb.adv && fillQ != '0) ? fillQ - 1'b1 : fillQ;
      fillSum    = {1'b0, fillShift} + (FILL_W + 1)'(strb.count);
      placed     = SCHED_W'(strb.bits) << fillShift;
    end

    assign ovfHit[s]  = strb.load[s] && (fillSum > (FILL_W + 1)'(SCHED_W));
    assign headBit[s] = schedQ[0];
    assign ctxArr[s]  = ctxQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        schedQ <= '0;
        fillQ  <= '0;
        ctxQ   <= '0;
      end else if (strb.load[s]) begin
        schedQ <= schedShift | placed;
        fillQ  <= ovfHit[s] ? FILL_W'(SCHED_W) : fillSum[FILL_W-1:0];
        ctxQ   <= insCtx;
      end else begin
        schedQ <= schedShift;
        fillQ  <= fillShift;
      end
    end
  end

  logic [CTX_W-1:0]  mergeOr;
  logic [KIND_W-1:0] kindOr, kindAnd;
  logic              anyActive, kindMixed;

  always_comb begin
    mergeOr = '0;
    kindOr  = '0;
    kindAnd = '1;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (headBit[s]) begin
        mergeOr = mergeOr | ctxArr[s];
        kindOr  = kindOr  | ctxArr[s][CTX_W-1 -: KIND_W];
        kindAnd = kindAnd & ctxArr[s][CTX_W-1 -: KIND_W];
      end
    end
    anyActive = |headBit;
    kindMixed = anyActive && (kindOr != kindAnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mergedCtx   <= '0;
      mergedValid <= 1'b0;
      illegalMix  <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      overflowErr <= overflowErr | (|ovfHit);
      if (strb.adv) begin
        mergedCtx   <= (anyActive && !kindMixed) ? mergeOr : '0;
        mergedValid <= anyActive && !kindMixed;
        illegalMix  <= kindMixed;
      end else begin
        mergedCtx   <= '0;
        mergedValid <= 1'b0;
        illegalMix  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctxprop_unit.sv
module ctxprop_unit
  import ctxprop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             insValid,
  input  logic [IDX_W-1:0] insIdx,
  input  logic [CTX_W-1:0] insCtx,
  input  logic [IMM_W-1:0] insImm,
  input  logic             advance,
  output logic [CTX_W-1:0] mergedCtx,
  output logic             mergedValid,
  output logic             illegalMix,
  output logic             overflowErr
);
  strobe_t strb;

  ctxprop_ctrl ctrl_i (
    .insValid (insValid),
    .insIdx   (insIdx),
    .insImm   (insImm),
    .advance  (advance),
    .strb     (strb)
  );

  ctxprop_datapath dp_i (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .insCtx      (insCtx),
    .mergedCtx   (mergedCtx),
    .mergedValid (mergedValid),
    .illegalMix  (illegalMix),
    .overflowErr (overflowErr)
  );
endmodule

// File: rtl/ctxprop_checker.sv
module ctxprop_checker
  import ctxprop_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             insValid,
  input logic             advance,
  input logic [CTX_W-1:0] mergedCtx,
  input logic             mergedValid,
  input logic             illegalMix,
  input logic             overflowErr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mergedValid && !illegalMix && !overflowErr && mergedCtx == '0));

  // R7
  valid_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mergedValid && illegalMix));

  // R10
  result_follows_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (mergedValid || illegalMix) |-> $past(advance));

  // R10
  idle_ctx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mergedValid |-> (mergedCtx == '0));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflowErr |=> overflowErr);

  // R8
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflowErr) |-> $past(insValid));
endmodule

bind ctxprop_unit ctxprop_checker chk_i (.*);

// File: tb/ctxprop_unit_tb_top.sv
module ctxprop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insValid = 1'b0;
  logic [2:0]  insIdx = '0;
  logic [31:0] insCtx = '0;
  logic [20:0] insImm = '0;
  logic        advance = 1'b0;
  logic [31:0] mergedCtx;
  logic        mergedValid, illegalMix, overflowErr;

  int nChecks = 0;
  int nFails  = 0;
  logic advSeen = 1'b0;
  logic [33:0] expQ[$];
  string       reqQ[$];

  localparam logic [31:0] CTX_A  = 32'h0000_00A1;
  localparam logic [31:0] CTX_B  = 32'h0000_0B00;
  localparam logic [31:0] CTX_C  = 32'h0000_C000;
  localparam logic [31:0] CTX_S  = 32'h1000_0005;
  localparam logic [31:0] CTX_S2 = 32'h1000_0030;
  localparam logic [31:0] CTX_R  = 32'h2000_0300;

  ctxprop_unit dut_i (
    .clk(clk), .rst(rst), .insValid(insValid), .insIdx(insIdx),
    .insCtx(insCtx), .insImm(insImm), .advance(advance),
    .mergedCtx(mergedCtx), .mergedValid(mergedValid),
    .illegalMix(illegalMix), .overflowErr(overflowErr)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual valid/illegal/ctx=%h expected=%h", req, act, exp);
    end
  endtask

  // Schedule bits b0 (applied first) .. b(n-1), then the terminator below them
  function automatic logic [20:0] mkImm(input logic [19:0] bits, input int n);
    return (21'(bits) << (21 - n)) | (21'(1) << (20 - n));
  endfunction

  task automatic ins(input logic [2:0] idx, input logic [31:0] ctx, input logic [20:0] imm);
    @(negedge clk);
    insValid = 1'b1; insIdx = idx; insCtx = ctx; insImm = imm;
    @(negedge clk);
    insValid = 1'b0; insIdx = '0; insCtx = '0; insImm = '0;
  endtask

  task automatic adv(input logic v, input logic il, input logic [31:0] c, input string req);
    @(negedge clk);
    advance = 1'b1;
    expQ.push_back({v, il, c});
    reqQ.push_back(req);
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic insAdv(input logic [2:0] idx, input logic [31:0] ctx, input logic [20:0] imm,
                        input logic v, input logic [31:0] c, input string req);
    @(negedge clk);
    insValid = 1'b1; insIdx = idx; insCtx = ctx; insImm = imm; advance = 1'b1;
    expQ.push_back({v, 1'b0, c});
    reqQ.push_back(req);
    @(negedge clk);
    insValid = 1'b0; insIdx = '0; insCtx = '0; insImm = '0; advance = 1'b0;
  endtask

  // Monitor: compare the result of every advance one cycle later
  always @(posedge clk) advSeen <= advance & ~rst;

  always @(negedge clk) begin
    if (advSeen) begin
      if (expQ.size() == 0) begin
        check("scoreboard underrun", {mergedValid, illegalMix, mergedCtx}, 34'h3_FFFF_FFFF);
      end else begin
        check(reqQ.pop_front(), {mergedValid, illegalMix, mergedCtx}, expQ.pop_front());
      end
    end
  end

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {mergedValid, illegalMix, mergedCtx}, 34'h0);
    check("R1 reset overflow", {33'h0, overflowErr}, 34'h0);
    adv(1'b0, 1'b0, 32'h0, "R1 advance after reset");

    // R3 / R5 order of schedule bits
    ins(3'd1, CTX_A, mkImm(20'b101, 3));
    adv(1'b1, 1'b0, CTX_A, "R3 first bit");
    adv(1'b0, 1'b0, 32'h0, "R3 second bit");
    adv(1'b1, 1'b0, CTX_A, "R3 third bit");
    adv(1'b0, 1'b0, 32'h0, "R5 stream drained");
    @(negedge clk);
    // R10 no advance in the previous cycle
    check("R10 idle outputs", {mergedValid, illegalMix, mergedCtx}, 34'h0);

    // R4 append after existing bits
    ins(3'd2, CTX_B, mkImm(20'b01, 2));
    ins(3'd2, CTX_B, mkImm(20'b11, 2));
    adv(1'b1, 1'b0, CTX_B, "R4 bit0");
    adv(1'b0, 1'b0, 32'h0, "R4 bit1");
    adv(1'b1, 1'b0, CTX_B, "R4 bit2");
    adv(1'b1, 1'b0, CTX_B, "R4 bit3");
    adv(1'b0, 1'b0, 32'h0, "R4 end");

    // R5 OR merge of two streams
    ins(3'd1, CTX_A, mkImm(20'b1, 1));
    ins(3'd2, CTX_B, mkImm(20'b1, 1));
    adv(1'b1, 1'b0, CTX_A | CTX_B, "R5 merge");

    // R7 mixed kinds then same kind
    ins(3'd1, CTX_A, mkImm(20'b1, 1));
    ins(3'd3, CTX_S, mkImm(20'b1, 1));
    adv(1'b0, 1'b1, 32'h0, "R7 mixed kinds");
    ins(3'd3, CTX_S, mkImm(20'b1, 1));
    ins(3'd4, CTX_S2, mkImm(20'b1, 1));
    adv(1'b1, 1'b0, CTX_S | CTX_S2, "R7 same kind");

    // R2 index 0 ignored
    ins(3'd5, CTX_R, mkImm(20'b1, 1));
    ins(3'd0, CTX_S, mkImm(20'hFFFFF, 20));
    adv(1'b1, 1'b0, CTX_R, "R2 index zero");
    adv(1'b0, 1'b0, 32'h0, "R2 nothing left");

    // R11 context replaced by later insert
    ins(3'd6, CTX_A, mkImm(20'b11, 2));
    ins(3'd6, CTX_B, 21'h10_0000);
    adv(1'b1, 1'b0, CTX_B, "R11 replaced ctx");
    adv(1'b1, 1'b0, CTX_B, "R11 replaced ctx second");

    // R3 zero immediate appends nothing
    ins(3'd7, CTX_A, 21'h0);
    adv(1'b0, 1'b0, 32'h0, "R3 zero immediate");

    // R6 empty stream offset floor
    adv(1'b0, 1'b0, 32'h0, "R6 empty");
    adv(1'b0, 1'b0, 32'h0, "R6 empty");
    ins(3'd1, CTX_A, mkImm(20'b1, 1));
    adv(1'b1, 1'b0, CTX_A, "R6 head after empty advances");

    // R9 insert and advance on the same edge
    ins(3'd2, CTX_B, mkImm(20'b11, 2));
    insAdv(3'd2, CTX_C, mkImm(20'b10, 2), 1'b1, CTX_B, "R9 advance uses old ctx");
    adv(1'b1, 1'b0, CTX_C, "R9 remaining old bit");
    adv(1'b0, 1'b0, 32'h0, "R9 new bit0");
    adv(1'b1, 1'b0, CTX_C, "R9 new bit1");
    adv(1'b0, 1'b0, 32'h0, "R9 end");

    // R8 overflow
    ins(3'd3, CTX_S, mkImm(20'hFFFFF, 20));
    ins(3'd3, CTX_S, mkImm(20'hFFFFF, 20));
    check("R8 exact fill no overflow", {33'h0, overflowErr}, 34'h0);
    ins(3'd3, CTX_S, mkImm(20'b1, 1));
    check("R8 overflow raised", {33'h0, overflowErr}, 34'h1);
    for (int k = 0; k < 40; k++) adv(1'b1, 1'b0, CTX_S, "R8 kept bits");
    adv(1'b0, 1'b0, 32'h0, "R8 dropped bit");
    check("R8 overflow sticky", {33'h0, overflowErr}, 34'h1);

    repeat (3) @(negedge clk);
    check("scoreboard drained", {2'b0, 32'(expQ.size())}, 34'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule